// File: doc/BRIEF.md
# Cascadable Loadable Binary Up-Counter

This block is a synchronous binary up-counter built from equal stages, each `WIDTH` bits wide (eight by default). Every stage can be loaded from a parallel data input. Counting is enabled by an active-low input. An active-high reset clears the stage at once, without waiting for a clock. Each stage drives an active-low flag that goes low while all of its bits are ones. Stages chain into one wider counter with no ripple logic in the count path. A stage counts on a given edge only when the chain enable is low and every stage below it shows its flag low.

A reload control turns the counter into a programmable divider. While it is high, the edge that would carry a stage past its all-ones value loads that stage's slice of the parallel input instead of wrapping to zero. The stage then counts on from the loaded value, so its period is set by that value. While the reload control is low, the stage wraps to zero and its flag returns high.

Top module: `casc_counter`

## Requirements
- R1: A high `mr` clears every count bit to zero at once, with no clock edge needed, and drives every `tc_n` bit high. While `mr` stays high, neither load nor count changes the value.
- R2: When `ld_n` is low, the next rising edge loads `din` into `q`, whatever `cnt_en_n` and `tc_reload` are.
- R3: When `ld_n` is high and `cnt_en_n` is high, `q` holds its value across the edge.
- R4: When `ld_n` is high and `cnt_en_n` is low, the chain counts up by one on each rising edge as a single `WIDTH*STAGES`-bit binary number. Bit 0 of `q` is the least significant bit.
- R5: `tc_n[i]` is low exactly when all bits of stage i (`q[i*WIDTH +: WIDTH]`) are ones, and high otherwise.
- R6: With `tc_reload` low, a stage that counts past all ones wraps to zero, and its `tc_n` bit returns high.
- R7: With `tc_reload` high, a stage that is at all ones and enabled to count loads its slice `din[i*WIDTH +: WIDTH]` on that edge instead of wrapping. The stages above it still count by one on that edge.
- R8: Stage i>0 changes on an edge (other than by load or reset) only when `cnt_en_n` is low and `tc_n[i-1:0]` are all low.
- R9: Reload acts only while counting is enabled. With `cnt_en_n` high, a stage at all ones holds its value even when `tc_reload` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all stages |
| mr | input | 1 | Asynchronous master reset, active high |
| ld_n | input | 1 | Parallel load, active low |
| cnt_en_n | input | 1 | Count enable for the lowest stage, active low |
| tc_reload | input | 1 | Reload the parallel input at all ones instead of wrapping |
| din | input | WIDTH*STAGES | Parallel load data |
| q | output | WIDTH*STAGES | Concatenated count value |
| tc_n | output | STAGES | Per-stage terminal count, active low |

## Verification
The bench builds the block with its default values, `WIDTH = 8` and `STAGES = 4`, which gives a 32-bit chain. With four stages, a carry can be checked as it passes through every stage boundary, including the case where it travels from the lowest byte to the highest on one edge. The 8-bit stage keeps reload periods short, so one reload cycle fits inside a single directed task. The tests place loaded values just below the boundaries, so wrap, reload and the chain-enable gating are reached in a few cycles.

// File: rtl/casc_counter_pkg.sv
package casc_counter_pkg;
   // next-state action chosen for one counter stage
   typedef enum logic [1:0] {
      OP_HOLD   = 2'd0,
      OP_LOAD   = 2'd1,
      OP_INC    = 2'd2,
      OP_RELOAD = 2'd3
   } cnt_op_e;
endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
   import casc_counter_pkg::*;
(
   input  logic    ld_n,
   input  logic    en_n,
   input  logic    reload,
   input  logic    at_max,
   output cnt_op_e op
);
   // priority: load, then hold, then terminal reload, then increment
   always_comb begin
      if (!ld_n)                op = OP_LOAD;
      else if (en_n)            op = OP_HOLD;
      else if (reload && at_max) op = OP_RELOAD;
      else                      op = OP_INC;
   end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
   import casc_counter_pkg::*;
#(
   parameter int WIDTH = 8
)(
   input  logic             clk,
   input  logic             mr,
   input  logic             ld_n,
   input  logic             en_n,
   input  logic             reload,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             tc_n
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   generate
      if (WIDTH < 2) begin : g_width_bad
         $error("cnt_stage: WIDTH must be at least 2");
      end
   endgenerate

   cnt_op_e op;
   logic    at_max;

   assign at_max = (q == ALL_ONES);
   assign tc_n   = ~at_max;

   cnt_op_decode u_dec (
      .ld_n   (ld_n),
      .en_n   (en_n),
      .reload (reload),
      .at_max (at_max),
      .op     (op)
   );

   always_ff @(posedge clk or posedge mr) begin
      if (mr) begin
         q <= '0;
      end else begin
         unique case (op)
            OP_LOAD, OP_RELOAD: q <= din;
            OP_INC:             q <= q + 1'b1;
            default:            q <= q;
         endcase
      end
   end

   // R2
   load_takes_din_chk: assert property (@(posedge clk) disable iff (mr)
      !ld_n |=> (q == $past(din)));

   // R3
   hold_when_disabled_chk: assert property (@(posedge clk) disable iff (mr)
      (ld_n && en_n) |=> $stable(q));

   // R4
   count_by_one_chk: assert property (@(posedge clk) disable iff (mr)
      (ld_n && !en_n && (q != ALL_ONES)) |=> (q == $past(q) + 1'b1));

   // R6
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (mr)
      (ld_n && !en_n && !reload && (q == ALL_ONES)) |=> ((q == '0) && tc_n));

   // R7
   reload_at_max_chk: assert property (@(posedge clk) disable iff (mr)
      (ld_n && !en_n && reload && (q == ALL_ONES)) |=> (q == $past(din)));
endmodule

// File: rtl/cnt_enable_chain.sv
module cnt_enable_chain #(
   parameter int STAGES = 4
)(
   input  logic              en_n,
   input  logic [STAGES-1:0] tc_n,
   output logic [STAGES-1:0] stage_en_n
);
   generate
      if (STAGES < 1) begin : g_stages_bad
         $error("cnt_enable_chain: STAGES must be at least 1");
      end
   endgenerate

   assign stage_en_n[0] = en_n;

   // each stage is disabled if any lower stage is not at its terminal count
   for (genvar i = 1; i < STAGES; i++) begin : g_or
      assign stage_en_n[i] = stage_en_n[i-1] | tc_n[i-1];
   end
endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 4
)(
   input  logic                    clk,
   input  logic                    mr,
   input  logic                    ld_n,
   input  logic                    cnt_en_n,
   input  logic                    tc_reload,
   input  logic [WIDTH*STAGES-1:0] din,
   output logic [WIDTH*STAGES-1:0] q,
   output logic [STAGES-1:0]       tc_n
);
   localparam int TOTAL = WIDTH * STAGES;

   generate
      if (TOTAL > 1024) begin : g_total_bad
         $error("casc_counter: WIDTH*STAGES must not exceed 1024");
      end
   endgenerate

   logic [STAGES-1:0] stage_en_n;

   cnt_enable_chain #(.STAGES(STAGES)) u_chain (
      .en_n       (cnt_en_n),
      .tc_n       (tc_n),
      .stage_en_n (stage_en_n)
   );

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      cnt_stage #(.WIDTH(WIDTH)) u_stage (
         .clk    (clk),
         .mr     (mr),
         .ld_n   (ld_n),
         .en_n   (stage_en_n[i]),
         .reload (tc_reload),
         .din    (din[i*WIDTH +: WIDTH]),
         .q      (q[i*WIDTH +: WIDTH]),
         .tc_n   (tc_n[i])
      );

      if (i > 0) begin : g_casc_chk
         // R8
         upper_gated_chk: assert property (@(posedge clk) disable iff (mr)
            (ld_n && (cnt_en_n || (tc_n[i-1:0] != '0)))
            |=> $stable(q[i*WIDTH +: WIDTH]));
      end
   end
endmodule

// File: tb/sim_casc_counter.sv
module sim_casc_counter;
   localparam int PERIOD = 10;
   localparam int W = 8;
   localparam int S = 4;
   localparam int T = W * S;

   logic         clk = 1'b0;
   logic         mr = 1'b1;
   logic         ld_n = 1'b1;
   logic         cnt_en_n = 1'b1;
   logic         tc_reload = 1'b0;
   logic [T-1:0] din = '0;
   logic [T-1:0] q;
   logic [S-1:0] tc_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #(PERIOD/2) clk = ~clk;

   casc_counter #(.WIDTH(W), .STAGES(S)) u0 (
      .clk(clk), .mr(mr), .ld_n(ld_n), .cnt_en_n(cnt_en_n),
      .tc_reload(tc_reload), .din(din), .q(q), .tc_n(tc_n)
   );

   task automatic chk(string req, logic [T-1:0] act, logic [T-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [S-1:0] exp_tc(logic [T-1:0] v);
      logic [S-1:0] r;
      for (int i = 0; i < S; i++) r[i] = ~&v[i*W +: W];
      return r;
   endfunction

   // expected next value from the requirements
   function automatic logic [T-1:0] model(logic [T-1:0] v);
      logic [T-1:0] n = v;
      bit en = !cnt_en_n;
      if (!ld_n) return din;
      for (int i = 0; i < S; i++) begin
         if (en) begin
            if (tc_reload && &v[i*W +: W]) n[i*W +: W] = din[i*W +: W];
            else n[i*W +: W] = v[i*W +: W] + 1'b1;
         end
         en = en && (&v[i*W +: W]);
      end
      return n;
   endfunction

   // one edge: inputs set at negedge, result sampled 1 unit after posedge
   task automatic step(string req);
      logic [T-1:0] e;
      e = model(q);
      @(posedge clk); #1;
      chk(req, q, e);
      chk({req, " R5 flag"}, T'(tc_n), T'(exp_tc(e)));
      @(negedge clk);
   endtask

   task automatic do_load(logic [T-1:0] v);
      ld_n = 1'b0; din = v;
      step("R2 load");
      ld_n = 1'b1;
   endtask

   task automatic t_reset;
      chk("R1 reset value", q, '0);
      chk("R1 reset flags", T'(tc_n), T'({S{1'b1}}));
      ld_n = 1'b0; din = 32'hA5A5_A5A5; cnt_en_n = 1'b0;
      @(posedge clk); #1;
      chk("R1 reset overrides load", q, '0);
      @(negedge clk);
      ld_n = 1'b1; cnt_en_n = 1'b1; mr = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_load_hold;
      cnt_en_n = 1'b0;
      do_load(32'h1234_5678);
      cnt_en_n = 1'b1;
      for (int k = 0; k < 3; k++) step("R3 hold");
      chk("R3 held value", q, 32'h1234_5678);
   endtask

   task automatic t_count;
      do_load(32'h0000_00FD);
      cnt_en_n = 1'b0;
      for (int k = 0; k < 5; k++) step("R4 count");
      chk("R4 across byte", q, 32'h0000_0102);
      cnt_en_n = 1'b1;
   endtask

   task automatic t_wrap;
      tc_reload = 1'b0;
      do_load(32'hFFFF_FFFE);
      cnt_en_n = 1'b0;
      step("R6 to max");
      chk("R5 all low at max", T'(tc_n), '0);
      step("R6 wrap");
      chk("R6 wrapped", q, '0);
      chk("R6 flags high", T'(tc_n), T'({S{1'b1}}));
      cnt_en_n = 1'b1;
   endtask

   task automatic t_reload;
      tc_reload = 1'b1;
      do_load(32'h0000_00FC);
      cnt_en_n = 1'b0;
      for (int k = 0; k < 9; k++) step("R7 reload");
      chk("R7 period", q, 32'h0000_02FD);
      cnt_en_n = 1'b1;
      do_load(32'h0000_00FF);
      step("R9 no reload when held");
      step("R9 no reload when held");
      chk("R9 held at max", q, 32'h0000_00FF);
      tc_reload = 1'b0;
   endtask

   task automatic t_cascade;
      do_load(32'h00FF_FFFE);
      cnt_en_n = 1'b0;
      for (int k = 0; k < 3; k++) step("R8 cascade");
      chk("R8 carry to top", q, 32'h0100_0001);
      cnt_en_n = 1'b1;
      do_load(32'h0000_FFFF);
      step("R8 gated by enable");
      step("R8 gated by enable");
      chk("R8 upper held", q, 32'h0000_FFFF);
   endtask

   task automatic t_async_mid;
      do_load(32'h0000_0010);
      cnt_en_n = 1'b0;
      step("R4 count");
      step("R4 count");
      #2 mr = 1'b1;
      #1;
      chk("R1 async clear", q, '0);
      chk("R1 async flags", T'(tc_n), T'({S{1'b1}}));
      @(negedge clk);
      mr = 1'b0; cnt_en_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      t_reset();
      t_load_hold();
      t_count();
      t_wrap();
      t_reload();
      t_cascade();
      t_async_mid();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(PERIOD * 20000);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule